// File: doc/BRIEF.md
# Grayscale PWM Channel Controller

This block turns a set of 12-bit grayscale words into one on/off drive signal per LED channel. A single shared grayscale counter sets the timing. Each channel switches on when the counter rolls over from its top value to zero, provided the channel's value is nonzero. It switches off once the counter has advanced as many steps as that value. Grayscale words come in on a parallel bus. A latch pulse captures them into a staging register (the first latch). They are copied into an active register (the second latch) either at once or at the next rollover, depending on the mode.

Everything runs on one oscillator clock. The counter steps on a tick, and a control input picks the source of that tick: every second oscillator cycle, or each rising edge of an external grayscale clock pin. The latch pulse, the external grayscale clock and the three control inputs each pass through a two-flop synchronizer. The latch pulse acts on its rising edge.

There are two modes for the latch pulse. In restart mode, the pulse presets the counter to a pre-boost value 16 steps below rollover, turns every output off, and loads both latches at once. In the other mode, the pulse loads only the first latch, and the running period carries on undisturbed. A repeat control decides whether outputs switch on again in every period, or only in the first period after a latch pulse.

Top module: `gs_pwm_ctrl`

## Requirements
- R1: While `rst_n` is low, every bit of `pwm_out` is 0, the counter is 000h, both latches hold zero and nothing is pending.
- R2: The counter advances by one on each tick and wraps from FFFh to 000h. In internal mode with repeat on, a channel's rising edges are 8192 clock cycles apart.
- R3: With `ctl_ext_clk` = 1, one tick occurs for each synchronized rising edge of `ext_gsclk`. With `ctl_ext_clk` = 0, one tick occurs on every second `clk` cycle.
- R4: A latch event with `ctl_restart` = 1 does three things. It loads the counter with FF0h. It drives all outputs to 0. It loads the first and second latches from `gs_data` on the same edge.
- R5: A latch event with `ctl_restart` = 0 loads only the first latch. The second latch takes the first latch's value at the next FFFh-to-000h wrap.
- R6: A channel with value V ≠ 0 turns on at the wrap and turns off on the tick that brings the counter to V, so it stays on for V ticks. Channel c occupies bits `gs_data[12c+11:12c]`.
- R7: A channel whose second-latch value is 000h never turns on.
- R8: With `ctl_repeat` = 0, outputs turn on only at the first wrap after a latch event. At later wraps they stay off until the next latch event.
- R9: With `ctl_repeat` = 1, outputs turn on at every wrap.
- R10: Timing of the synchronized inputs:
  - `latch_in`, `ext_gsclk` and the control inputs act on the third rising clock edge after a change is set up.
  - A latch event is the 0-to-1 transition of the synchronized `latch_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_gsclk | input | 1 | External grayscale clock, asynchronous |
| latch_in | input | 1 | Latch request; acts on its synchronized rising edge |
| ctl_ext_clk | input | 1 | 1: tick from ext_gsclk edges; 0: tick from clk divided by two |
| ctl_restart | input | 1 | 1: a latch event presets the counter and loads both latches |
| ctl_repeat | input | 1 | 1: outputs turn on in every period |
| gs_data | input | NCH*12 | Parallel grayscale words, channel c in bits 12c+11:12c |
| pwm_out | output | NCH | On/off drive, one bit per channel |

## Verification
The properties assume three things about the inputs. `gs_data` stays stable while a latch request passes through the synchronizer. `ext_gsclk` stays at each level for at least two `clk` cycles, so that no edge is lost. Control inputs change only together with, or ahead of, a latch request, never at random. The stimulus changes data and controls on falling clock edges, a few cycles before it raises `latch_in`. It holds `latch_in` high for four cycles and toggles `ext_gsclk` every two cycles. A behavioural model in the bench predicts every output on every cycle from the synchronized view of the same inputs.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;
    // Synchronized control word
    typedef struct packed {
        logic use_ext;
        logic restart;
        logic repeat_on;
    } gs_ctl_t;
endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/gs_tick_gen.sv
module gs_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic use_ext,
    input  logic ext_lvl,
    output logic tick
);
    typedef struct packed {
        logic div;
        logic ext_prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.div      = ~st_q.div;
        st_d.ext_prev = ext_lvl;
        tick = use_ext ? (ext_lvl & ~st_q.ext_prev) : st_q.div;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gs_channel.sv
module gs_channel #(
    parameter int GSW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           wrap,
    input  logic           clr,
    input  logic           go,
    input  logic [GSW-1:0] val,
    input  logic [GSW-1:0] cnt_nx,
    output logic           on
);
    typedef struct packed {
        logic on;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)                       st_d.on = 1'b0;
        else if (wrap)                 st_d.on = go && (val != '0);
        else if (step && cnt_nx == val) st_d.on = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on = st_q.on;
endmodule

// File: rtl/gs_pwm_ctrl.sv
module gs_pwm_ctrl
    import gs_pwm_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int GSW         = 12,
    parameter int PREBOOST_LEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_gsclk,
    input  logic               latch_in,
    input  logic               ctl_ext_clk,
    input  logic               ctl_restart,
    input  logic               ctl_repeat,
    input  logic [NCH*GSW-1:0] gs_data,
    output logic [NCH-1:0]     pwm_out
);
    localparam logic [GSW-1:0] PRELOAD = GSW'((2 ** GSW) - PREBOOST_LEN);
    localparam int             SYNC_W  = 5;

    typedef struct packed {
        logic [GSW-1:0]     cnt;
        logic               arm;
        logic               lat_prev;
        logic [NCH*GSW-1:0] l1;
        logic [NCH*GSW-1:0] l2;
    } st_t;

    st_t             st_d, st_q;
    logic [SYNC_W-1:0] sync_q;
    gs_ctl_t         ctl_s;
    logic            lat_s, ext_s;
    logic            tick, lat_ev, dtr_ev, wrap, step, go;

    gs_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_gsclk, latch_in, ctl_ext_clk, ctl_restart, ctl_repeat}),
        .q     (sync_q)
    );

    assign ext_s = sync_q[4];
    assign lat_s = sync_q[3];
    assign ctl_s = gs_ctl_t'(sync_q[2:0]);

    gs_tick_gen u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_ext (ctl_s.use_ext),
        .ext_lvl (ext_s),
        .tick    (tick)
    );

    always_comb begin
        st_d          = st_q;
        st_d.lat_prev = lat_s;
        lat_ev        = lat_s & ~st_q.lat_prev;
        dtr_ev        = lat_ev & ctl_s.restart;
        step          = tick & ~dtr_ev;
        wrap          = step & (st_q.cnt == '1);
        go            = st_q.arm | ctl_s.repeat_on;

        if (dtr_ev) begin
            st_d.cnt = PRELOAD;
            st_d.l2  = gs_data;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (wrap) begin
                st_d.l2  = st_q.l1;
                st_d.arm = 1'b0;
            end
        end

        if (lat_ev) begin
            st_d.l1  = gs_data;
            st_d.arm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gs_channel #(.GSW(GSW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (step),
            .wrap   (wrap),
            .clr    (dtr_ev),
            .go     (go),
            .val    (st_d.l2[c*GSW +: GSW]),
            .cnt_nx (st_d.cnt),
            .on     (pwm_out[c])
        );
    end
endmodule

// File: rtl/gs_pwm_ctrl_chk.sv
module gs_pwm_ctrl_chk #(
    parameter int             NCH     = 4,
    parameter int             GSW     = 12,
    parameter logic [GSW-1:0] PRELOAD = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               dtr_ev,
    input logic [GSW-1:0]     cnt,
    input logic [NCH*GSW-1:0] l2,
    input logic [NCH-1:0]     pwm
);
    assert_preboost_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dtr_ev |=> cnt == PRELOAD);

    assert_preboost_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dtr_ev |=> pwm == '0);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dtr_ev) |=> cnt == GSW'($past(cnt) + 1'b1));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !dtr_ev) |=> $stable(cnt));

    assert_second_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && cnt == '1) && !dtr_ev) |=> $stable(l2));

    for (genvar c = 0; c < NCH; c++) begin : g_zero
        assert_zero_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
            pwm[c] |-> (l2[c*GSW +: GSW] != '0));
    end
endmodule

bind gs_pwm_ctrl gs_pwm_ctrl_chk #(.NCH(NCH), .GSW(GSW), .PRELOAD(PRELOAD)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .dtr_ev (dtr_ev),
    .cnt    (st_q.cnt),
    .l2     (st_q.l2),
    .pwm    (pwm_out)
);

// File: tb/gs_pwm_ctrl_test.sv
`timescale 1ns/1ps
module gs_pwm_ctrl_test;
    localparam int NCH = 4;
    localparam int GSW = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ext_gsclk = 1'b0;
    logic               latch_in = 1'b0;
    logic               ctl_ext_clk = 1'b0;
    logic               ctl_restart = 1'b0;
    logic               ctl_repeat = 1'b0;
    logic [NCH*GSW-1:0] gs_data = '0;
    logic [NCH-1:0]     pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit ext_run = 0;

    gs_pwm_ctrl #(.NCH(NCH), .GSW(GSW)) uut (
        .clk(clk), .rst_n(rst_n), .ext_gsclk(ext_gsclk), .latch_in(latch_in),
        .ctl_ext_clk(ctl_ext_clk), .ctl_restart(ctl_restart), .ctl_repeat(ctl_repeat),
        .gs_data(gs_data), .pwm_out(pwm_out)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference model
    bit lh1, lh2, lh3, eh1, eh2, eh3, div;
    bit ce1, ce2, cr1, cr2, cp1, cp2;
    int mcnt;
    bit marm;
    int ml1[NCH];
    int ml2[NCH];
    bit mon[NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            {lh1, lh2, lh3, eh1, eh2, eh3, div} = '0;
            {ce1, ce2, cr1, cr2, cp1, cp2} = '0;
            mcnt = 0; marm = 0;
            for (int c = 0; c < NCH; c++) begin ml1[c] = 0; ml2[c] = 0; mon[c] = 0; end
        end else begin
            bit ev, tk, old_arm;
            ev = lh2 && !lh3;
            tk = ce2 ? (eh2 && !eh3) : div;
            old_arm = marm;
            if (ev && cr2) begin
                mcnt = 'hFF0;
                for (int c = 0; c < NCH; c++) begin
                    ml1[c] = int'(gs_data[c*GSW +: GSW]);
                    ml2[c] = ml1[c];
                    mon[c] = 0;
                end
                marm = 1;
            end else begin
                if (tk) begin
                    if (mcnt == 4095) begin
                        mcnt = 0;
                        marm = 0;
                        for (int c = 0; c < NCH; c++) begin
                            ml2[c] = ml1[c];
                            mon[c] = (old_arm || cp2) && ml2[c] != 0;
                        end
                    end else begin
                        mcnt = mcnt + 1;
                        for (int c = 0; c < NCH; c++) if (mcnt == ml2[c]) mon[c] = 0;
                    end
                end
                if (ev) begin
                    for (int c = 0; c < NCH; c++) ml1[c] = int'(gs_data[c*GSW +: GSW]);
                    marm = 1;
                end
            end
            lh3 = lh2; lh2 = lh1; lh1 = latch_in;
            eh3 = eh2; eh2 = eh1; eh1 = ext_gsclk;
            ce2 = ce1; ce1 = ctl_ext_clk;
            cr2 = cr1; cr1 = ctl_restart;
            cp2 = cp1; cp1 = ctl_repeat;
            div = !div;
        end
    end

    // Per-cycle comparison and edge timing monitor
    int cyc = 0;
    int rise_t[NCH];
    int hi_len[NCH];
    int period[NCH];
    int rises[NCH];
    bit ever_hi[NCH];
    logic [NCH-1:0] prev_pwm = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            for (int c = 0; c < NCH; c++) begin
                n_cmp++;
                if (pwm_out[c] !== mon[c]) begin
                    n_bad++;
                    $display("FAIL R6 R10 ch%0d cycle %0d: actual %b expected %b", c, cyc, pwm_out[c], mon[c]);
                end
                if (pwm_out[c] && !prev_pwm[c]) begin
                    if (rises[c] > 0) period[c] = cyc - rise_t[c];
                    rise_t[c] = cyc;
                    rises[c]++;
                end
                if (!pwm_out[c] && prev_pwm[c]) hi_len[c] = cyc - rise_t[c];
                if (pwm_out[c]) ever_hi[c] = 1;
            end
            prev_pwm = pwm_out;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        for (int c = 0; c < NCH; c++) begin
            rises[c] = 0; hi_len[c] = -1; period[c] = -1; ever_hi[c] = 0;
        end
    endtask

    task automatic do_latch(input bit ext, input bit rst_mode, input bit rpt,
                            input int v0, input int v1, input int v2, input int v3);
        @(negedge clk);
        ctl_ext_clk = ext; ctl_restart = rst_mode; ctl_repeat = rpt;
        gs_data = {GSW'(v3), GSW'(v2), GSW'(v1), GSW'(v0)};
        repeat (3) @(negedge clk);
        latch_in = 1'b1;
        repeat (4) @(negedge clk);
        latch_in = 1'b0;
    endtask

    initial begin : ext_drv
        forever begin
            repeat (2) @(negedge clk);
            if (ext_run) ext_gsclk = ~ext_gsclk;
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        clear_stats();
        repeat (5) @(negedge clk);
        chk(pwm_out == '0, "R1 reset outputs", int'(pwm_out), 0);
        rst_n = 1'b1;

        // A: internal tick, restart mode, repeat on
        clear_stats();
        do_latch(0, 1, 1, 'h001, 'h000, 'h3FF, 'hFFF);
        repeat (32 + 2 * 8192 + 50) @(negedge clk);
        chk(hi_len[0] == 2,    "R6 value 001h on-time", hi_len[0], 2);
        chk(hi_len[2] == 2046, "R6 value 3FFh on-time", hi_len[2], 2046);
        chk(hi_len[3] == 8190, "R6 value FFFh on-time", hi_len[3], 8190);
        chk(period[0] == 8192, "R2 period length", period[0], 8192);
        chk(rises[2] >= 2,     "R9 repeat turns on each period", rises[2], 2);
        chk(ever_hi[1] == 0,   "R7 zero channel dark", int'(ever_hi[1]), 0);
        chk(pwm_out[3] == 1'b1, "R3 internal tick running", int'(pwm_out[3]), 1);

        // B: restart mode, repeat off
        clear_stats();
        fork
            do_latch(0, 1, 0, 'h400, 'h000, 'h000, 'h000);
            begin
                repeat (4 + 4) @(negedge clk);
                chk(pwm_out == '0, "R4 outputs dark after restart latch", int'(pwm_out), 0);
            end
        join
        repeat (32 + 3 * 8192 + 50) @(negedge clk);
        chk(rises[0] == 1,     "R8 single period without repeat", rises[0], 1);
        chk(hi_len[0] == 2048, "R4 value 400h on-time after pre-boost", hi_len[0], 2048);

        // C: staged latch only, repeat on
        clear_stats();
        do_latch(0, 0, 1, 'h002, 'h000, 'h000, 'h001);
        repeat (2 * 8192 + 50) @(negedge clk);
        chk(hi_len[0] == 4, "R5 staged value applied at wrap", hi_len[0], 4);
        chk(hi_len[3] == 2, "R5 staged value ch3", hi_len[3], 2);

        // D: external tick, ext clock period of 4 clk cycles
        ext_run = 1;
        clear_stats();
        do_latch(1, 1, 1, 'h005, 'h000, 'h000, 'h000);
        repeat (16 * 4 + 4096 * 4 + 100) @(negedge clk);
        chk(hi_len[0] == 20, "R3 external tick on-time", hi_len[0], 20);
        chk(ever_hi[1] == 0, "R7 zero channel dark external", int'(ever_hi[1]), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule